// File: doc/BRIEF.md
# Calibrated Real-Time Clock with Alarm

This peripheral keeps wall time for a chip running from a slow crystal of roughly 33.33 kHz. A sub-second tick counter divides the crystal clock down to one pulse per second. The reload point of that divider comes from a packed calibration word. The word holds an integer tick limit, a 4-bit fractional correction count and an enable bit for the correction. When the correction is enabled, a few seconds in every sixteen are lengthened by one crystal cycle, so the average rate can be trimmed below one tick of resolution.

Each second pulse advances a 32-bit seconds counter. Software can preload the counter through a set-time register, and the preload takes effect on the following second boundary. A 32-bit alarm register is compared with the seconds value each time that value changes. Two interrupt sources, the seconds pulse and the alarm match, share one status register that software clears by writing ones. Each source has a mask bit, cleared through an enable strobe register and set through a disable strobe register. Each source drives its own level interrupt line.

Software reaches the block through a simple 32-bit register port in the crystal clock domain. Writes take effect on the clock edge that samples them. Read data is registered and is valid one cycle after the read strobe.

Top module: `rtc_calib_top`

## Requirements
- R1: After reset, calibration reads back 0x198233 at 0x0C, mask reads 2'b11 at 0x24, status at 0x20, control at 0x40, seconds at 0x10 and tick at 0x14 all read 0, and both interrupt lines are low.
- R2: While control bit 24 is 1, the tick counter steps 0,1,..,L, where L is calibration bits 15:0, and then returns to 0 and raises a second boundary, so one second lasts L+1 cycles. While bit 24 is 0, the tick counter and the seconds counter hold their values.
- R3: When calibration bit 20 is 1, each second lasts one extra cycle if its window index is below calibration bits 19:16. The window index counts elapsed seconds modulo 16 from reset. When bit 20 is 0, the fraction field has no effect.
- R4: The 32-bit seconds counter rolls over from 0xFFFFFFFF to 0.
- R5: A write to 0x00 stores a value that reads back at 0x04. At the next second boundary, the seconds counter takes that value in place of the increment. Until that boundary, the counter keeps its old value.
- R6: Status bit 0 is set at every second boundary. Status bit 1 is set at a boundary whose new seconds value equals the alarm register. The alarm register is written and read at 0x18 and resets to 0.
- R7: Writing 0x20 clears each status bit that is written as 1 and leaves each bit written as 0 unchanged.
- R8: A 1 written at 0x28 clears the matching mask bit, a 1 written at 0x2C sets it, and a 0 in either strobe leaves the bit unchanged. Bit 0 is the seconds source and bit 1 is the alarm source.
- R9: irq_sec equals status bit 0 AND NOT mask bit 0, and irq_alarm equals status bit 1 AND NOT mask bit 1. Both are levels.
- R10: Read data appears on bus_rdata the cycle after bus_rd. The tick counter reads in bits 15:0 of 0x14, and the oscillator enable reads and writes at bit 24 of 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock; also clocks the register port |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_sec | output | 1 | Seconds interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The bench targets the calibration corners. A limit of 0 must give one second per cycle; a design that compares with the wrong bound would stall or double the period. The full fraction of 15 must lengthen every second except the last in the window, and an off-by-one window compare would shift the final second count. A fraction with the enable bit cleared must be ignored. The bench also crosses the 32-bit rollover after a preload, since a design that applies the set-time value at once, or that applies it again, would read the wrong second. It confirms that writing zeros to the clear register keeps pending status, and that masking silences one line while leaving the other asserted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 7;
  localparam int NSRC   = 2;

  localparam logic [ADDR_W-1:0] A_SETTIME_WR = 7'h00;
  localparam logic [ADDR_W-1:0] A_SETTIME_RD = 7'h04;
  localparam logic [ADDR_W-1:0] A_CAL_WR     = 7'h08;
  localparam logic [ADDR_W-1:0] A_CAL_RD     = 7'h0C;
  localparam logic [ADDR_W-1:0] A_SECONDS    = 7'h10;
  localparam logic [ADDR_W-1:0] A_TICK       = 7'h14;
  localparam logic [ADDR_W-1:0] A_ALARM      = 7'h18;
  localparam logic [ADDR_W-1:0] A_STATUS     = 7'h20;
  localparam logic [ADDR_W-1:0] A_MASK       = 7'h24;
  localparam logic [ADDR_W-1:0] A_UNMASK     = 7'h28;
  localparam logic [ADDR_W-1:0] A_REMASK     = 7'h2C;
  localparam logic [ADDR_W-1:0] A_CTRL       = 7'h40;

  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;
  localparam int OSC_BIT   = 24;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [TICK_W-1:0] limit,
  input  logic [FRAC_W-1:0] frac,
  input  logic              frac_en,
  output logic [TICK_W-1:0] tick,
  output logic              sec_stb
);
  localparam int CW = TICK_W + 1;

  logic [CW-1:0]     cnt_q;
  logic [FRAC_W-1:0] win_q;
  logic              stretch;
  logic [CW-1:0]     wrap_at;

  assign stretch = frac_en && (win_q < frac);
  assign wrap_at = {1'b0, limit} + CW'(stretch);
  assign sec_stb = run && (cnt_q >= wrap_at);
  assign tick    = cnt_q[TICK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (run) begin
      if (sec_stb) begin
        cnt_q <= '0;
        win_q <= win_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_stb,
  input  logic             load_wr,
  input  logic [SEC_W-1:0] load_val,
  input  logic [SEC_W-1:0] alarm_val,
  output logic [SEC_W-1:0] seconds,
  output logic [SEC_W-1:0] load_hold,
  output logic             load_pend,
  output logic             alarm_hit
);
  logic [SEC_W-1:0] sec_q, hold_q, sec_next;
  logic             pend_q;

  assign sec_next  = pend_q ? hold_q : sec_q + 1'b1;
  assign alarm_hit = sec_stb && (sec_next == alarm_val);
  assign seconds   = sec_q;
  assign load_hold = hold_q;
  assign load_pend = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (sec_stb) begin
        sec_q  <= sec_next;
        pend_q <= 1'b0;
      end
      if (load_wr) begin
        hold_q <= load_val;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic         dis_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic st_q, mk_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= 1'b0;
        mk_q <= 1'b1;
      end else begin
        if (clr_wr && wbits[i]) st_q <= 1'b0;
        if (set[i])             st_q <= 1'b1;
        if (en_wr && wbits[i])  mk_q <= 1'b0;
        if (dis_wr && wbits[i]) mk_q <= 1'b1;
      end
    end
    assign status[i] = st_q;
    assign mask[i]   = mk_q;
    assign irq[i]    = st_q & ~mk_q;
  end
endmodule

// File: rtl/rtc_calib_top.sv
module rtc_calib_top
  import rtc_pkg::*;
#(
  parameter int          SEC_W   = 32,
  parameter int          TICK_W  = 16,
  parameter int          FRAC_W  = 4,
  parameter logic [31:0] CAL_RST = 32'h0019_8233
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  localparam int CAL_W = TICK_W + FRAC_W + 1;

  logic [CAL_W-1:0]  cal_q;
  logic [SEC_W-1:0]  alarm_q;
  logic              osc_en_q;
  logic [31:0]       rdata_q;

  logic [TICK_W-1:0] tick_cnt;
  logic              sec_stb;
  logic [SEC_W-1:0]  seconds_q, hold_val;
  logic              load_pend, alarm_hit;
  logic [NSRC-1:0]   status_q, mask_q, irq_vec, src_set;

  logic wr_set, wr_cal, wr_alarm, wr_sts, wr_en, wr_dis, wr_ctrl;
  assign wr_set   = bus_wr && (bus_addr == A_SETTIME_WR);
  assign wr_cal   = bus_wr && (bus_addr == A_CAL_WR);
  assign wr_alarm = bus_wr && (bus_addr == A_ALARM);
  assign wr_sts   = bus_wr && (bus_addr == A_STATUS);
  assign wr_en    = bus_wr && (bus_addr == A_UNMASK);
  assign wr_dis   = bus_wr && (bus_addr == A_REMASK);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q    <= CAL_RST[CAL_W-1:0];
      alarm_q  <= '0;
      osc_en_q <= 1'b0;
    end else begin
      if (wr_cal)   cal_q    <= bus_wdata[CAL_W-1:0];
      if (wr_alarm) alarm_q  <= bus_wdata[SEC_W-1:0];
      if (wr_ctrl)  osc_en_q <= bus_wdata[OSC_BIT];
    end
  end

  rtc_prescaler #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_presc (
    .clk(clk), .rst(rst), .run(osc_en_q),
    .limit(cal_q[TICK_W-1:0]),
    .frac(cal_q[TICK_W +: FRAC_W]),
    .frac_en(cal_q[CAL_W-1]),
    .tick(tick_cnt), .sec_stb(sec_stb)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_secs (
    .clk(clk), .rst(rst), .sec_stb(sec_stb),
    .load_wr(wr_set), .load_val(bus_wdata[SEC_W-1:0]),
    .alarm_val(alarm_q), .seconds(seconds_q), .load_hold(hold_val),
    .load_pend(load_pend), .alarm_hit(alarm_hit)
  );

  always_comb begin
    src_set            = '0;
    src_set[SRC_SEC]   = sec_stb;
    src_set[SRC_ALARM] = alarm_hit;
  end

  rtc_irq_ctl #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set(src_set),
    .clr_wr(wr_sts), .en_wr(wr_en), .dis_wr(wr_dis),
    .wbits(bus_wdata[NSRC-1:0]),
    .status(status_q), .mask(mask_q), .irq(irq_vec)
  );

  assign irq_sec   = irq_vec[SRC_SEC];
  assign irq_alarm = irq_vec[SRC_ALARM];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_SETTIME_RD: rdata_q <= 32'(hold_val);
        A_CAL_RD:     rdata_q <= 32'(cal_q);
        A_SECONDS:    rdata_q <= 32'(seconds_q);
        A_TICK:       rdata_q <= 32'(tick_cnt);
        A_ALARM:      rdata_q <= 32'(alarm_q);
        A_STATUS:     rdata_q <= 32'(status_q);
        A_MASK:       rdata_q <= 32'(mask_q);
        A_CTRL:       rdata_q <= 32'(osc_en_q) << OSC_BIT;
        default:      rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/rtc_calib_chk.sv
module rtc_calib_chk
  import rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sec_stb,
  input logic              load_pend,
  input logic              osc_en_q,
  input logic [SEC_W-1:0]  seconds_q,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_alarm
);
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sec_stb |=> $stable(seconds_q)); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (sec_stb && !load_pend) |=> seconds_q == $past(seconds_q) + 1'b1); // R4
  AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !osc_en_q |=> $stable(tick_cnt)); // R2
  AST_STS_SEC: assert property (@(posedge clk) disable iff (rst)
    sec_stb |=> status_q[SRC_SEC]); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STATUS && bus_wdata[SRC_SEC] && !sec_stb)
      |=> !status_q[SRC_SEC]); // R7
  AST_UNMASK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_UNMASK && bus_wdata[SRC_ALARM])
      |=> !mask_q[SRC_ALARM]); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    mask_q[SRC_ALARM] |-> !irq_alarm); // R9
endmodule

bind rtc_calib_top rtc_calib_chk #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sec_stb(sec_stb), .load_pend(load_pend),
  .osc_en_q(osc_en_q), .seconds_q(seconds_q), .tick_cnt(tick_cnt),
  .status_q(status_q), .mask_q(mask_q), .irq_alarm(irq_alarm)
);

// File: tb/tb_rtc_calib_top.sv
module tb_rtc_calib_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_sec, irq_alarm;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  rtc_calib_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  typedef struct packed {
    logic [20:0] cal;
    logic [15:0] cyc;
    logic [31:0] sec;
    logic [15:0] tick;
  } vec_t;

  // calibration word, enabled cycles, expected seconds, expected tick
  localparam vec_t VECS [7] = '{
    '{21'h000004, 16'd23, 32'd4,  16'd3},  // R2 plain divide by 5
    '{21'h120004, 16'd23, 32'd4,  16'd1},  // R3 two stretched seconds
    '{21'h000009, 16'd10, 32'd1,  16'd0},  // R2 exactly one second
    '{21'h000000, 16'd7,  32'd7,  16'd0},  // R2 limit zero
    '{21'h1F0002, 16'd65, 32'd16, 16'd2},  // R3 full fraction, window wrap
    '{21'h0F0002, 16'd65, 32'd21, 16'd2},  // R3 fraction ignored when off
    '{21'h100003, 16'd9,  32'd2,  16'd1}   // R3 enabled, zero fraction
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // oscillator enabled for exactly c counting edges
  task automatic run(input int c);
    wr(7'h40, 32'h0100_0000);
    repeat (c - 1) @(negedge clk);
    wr(7'h40, 32'h0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      do_reset();
      wr(7'h08, 32'(VECS[i].cal));
      run(int'(VECS[i].cyc));
      rd(7'h10, v);  check($sformatf("R2/R3 vec%0d seconds", i), v, VECS[i].sec);
      rd(7'h14, v);  check($sformatf("R10 vec%0d tick", i), v, 32'(VECS[i].tick));
    end

    // R1 reset state
    do_reset();
    check("R1 irq_sec", 32'(irq_sec), 0);
    check("R1 irq_alarm", 32'(irq_alarm), 0);
    rd(7'h0C, v); check("R1 calibration", v, 32'h0019_8233);
    rd(7'h24, v); check("R1 mask", v, 32'h3);
    rd(7'h20, v); check("R1 status", v, 32'h0);
    rd(7'h40, v); check("R1 control", v, 32'h0);
    rd(7'h10, v); check("R1 seconds", v, 32'h0);
    rd(7'h14, v); check("R1 tick", v, 32'h0);

    // R10 control readback
    wr(7'h40, 32'h0100_0000);
    rd(7'h40, v); check("R10 control bit24", v, 32'h0100_0000);
    wr(7'h40, 32'h0);

    // R5 preload, R4 rollover
    do_reset();
    wr(7'h08, 32'h4);
    wr(7'h00, 32'hFFFF_FFFE);
    rd(7'h04, v); check("R5 set-time readback", v, 32'hFFFF_FFFE);
    rd(7'h10, v); check("R5 not loaded before boundary", v, 32'h0);
    run(5);
    rd(7'h10, v); check("R5 loaded at boundary", v, 32'hFFFF_FFFE);
    run(5);
    rd(7'h10, v); check("R5 single load then increment", v, 32'hFFFF_FFFF);
    run(5);
    rd(7'h10, v); check("R4 rollover", v, 32'h0);
    rd(7'h20, v); check("R6 tick and alarm(0) status", v, 32'h3);

    // R2 frozen while disabled
    run(2);
    rd(7'h14, v);
    repeat (10) @(negedge clk);
    rd(7'h14, v2); check("R2 tick frozen when off", v2, v);
    check("R2 tick value", v, 32'h2);

    // R7 write-one-to-clear
    wr(7'h20, 32'h0);
    rd(7'h20, v); check("R7 zero write keeps status", v, 32'h3);
    wr(7'h20, 32'h1);
    rd(7'h20, v); check("R7 clear bit0 only", v, 32'h2);
    wr(7'h20, 32'h2);
    rd(7'h20, v); check("R7 clear bit1", v, 32'h0);

    // R6 alarm compare
    wr(7'h18, 32'h2);
    rd(7'h18, v); check("R6 alarm readback", v, 32'h2);
    run(3);                          // tick 2 -> finishes second 0 -> 1
    rd(7'h10, v); check("R6 seconds one", v, 32'h1);
    rd(7'h20, v); check("R6 no match", v, 32'h1);
    wr(7'h20, 32'h1);
    run(5);
    rd(7'h10, v); check("R6 seconds two", v, 32'h2);
    rd(7'h20, v); check("R6 alarm match", v, 32'h3);
    check("R9 masked sec", 32'(irq_sec), 0);
    check("R9 masked alarm", 32'(irq_alarm), 0);

    // R8 mask strobes, R9 gating
    wr(7'h28, 32'h2);
    rd(7'h24, v); check("R8 enable alarm", v, 32'h1);
    check("R9 alarm line up", 32'(irq_alarm), 1);
    check("R9 sec line still low", 32'(irq_sec), 0);
    wr(7'h28, 32'h1);
    check("R9 sec line up", 32'(irq_sec), 1);
    wr(7'h2C, 32'h2);
    rd(7'h24, v); check("R8 disable alarm", v, 32'h2);
    check("R9 alarm line masked", 32'(irq_alarm), 0);
    check("R9 sec line kept", 32'(irq_sec), 1);
    wr(7'h2C, 32'h0);
    rd(7'h24, v); check("R8 zero strobe no effect", v, 32'h2);
    wr(7'h20, 32'h1);
    check("R7 clear drops sec line", 32'(irq_sec), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule